// File: doc/BRIEF.md
# Doubling Register Peripheral with DMA Result Push

This peripheral sits on a simple host request/response bus and presents four register windows, each occupying a 64-byte aperture selected by the top two address bits. A one-byte write to the data window stores twice the byte and raises the interrupt. A one-byte write to the compute window doubles the byte and sends that result to system memory through a single-beat write-master port. The interrupt is raised only once that port reports the write as committed. A separate window holds the interrupt flag, which software can read, set or clear. A fourth window holds the 64-bit memory target address, loaded as two independently written 32-bit halves.

Host requests carry a byte-count field. Every window except the address window accepts single-byte accesses only. An accepted request is answered one cycle later on the response port. While a memory write is still outstanding, a further compute write is stalled through a wait signal until the write master signals completion. The interrupt output is a level that follows the flag.

Top module: `dbl_dma_periph`

## Requirements
- R1: After reset the stored data value, the 64-bit target address and the interrupt flag are zero, `irq` is low and `dma_valid` is low.
- R2: A 1-byte write (req_size = 0) to the data window (req_addr[7:6] = 0) stores 2 × req_wdata[7:0] as a 9-bit value with no truncation, and drives `irq` high in the cycle after the accepting edge.
- R3: An accepted request yields `rsp_valid` high in the following cycle. For a 1-byte read of the data window, `rsp_rdata` holds the stored value zero-extended.
- R4: On the data, compute and interrupt windows, a write whose req_size is not 0 changes no state, starts no memory write and leaves `irq` unchanged. A read whose req_size is not 0 returns 0xFFFFFFFF.
- R5: A 1-byte write to the compute window (req_addr[7:6] = 1) drives `dma_valid` high in the next cycle, with `dma_addr` equal to the target address and `dma_data` equal to 2 × req_wdata[7:0]. These values hold steady until `dma_done` is sampled high, and `dma_valid` is low in the cycle after that.
- R6: A compute write sets the flag and `irq` in the cycle after `dma_done` is sampled high with `dma_valid`, and not earlier.
- R7: While `dma_valid` is high, a 1-byte compute write sees `req_wait` high and is not accepted. It is accepted at the first edge after the outstanding write completes. `req_wait` is never high for any other request.
- R8: Any read of the compute window or of the address window (req_addr[7:6] = 3) returns 0xFFFFFFFF.
- R9: On the interrupt window (req_addr[7:6] = 2), a 1-byte read returns the flag in bit 0 with the other bits zero. A 1-byte write of a nonzero byte sets the flag and `irq`, and a write of zero clears both.
- R10: A write with req_size = 2 (4 bytes) to the address window at offset 0 replaces address bits 31:0, and at offset 4 replaces bits 63:32, leaving the other half intact. Any other size or offset there is ignored.
- R11: Byte data travels in req_wdata[7:0]. In the data, compute and interrupt windows the offset bits req_addr[5:0] do not affect behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Window select [7:6] and aperture offset [5:0] |
| req_size | input | 2 | Access size as log2 of bytes: 0 = 1 B, 1 = 2 B, 2 = 4 B, 3 = 8 B |
| req_wdata | input | 32 | Write data, little-endian |
| req_wait | output | 1 | Request held off this cycle |
| rsp_valid | output | 1 | Response for the request accepted last cycle |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| dma_valid | output | 1 | Memory write outstanding |
| dma_addr | output | 64 | Memory write target address |
| dma_data | output | 16 | Memory write payload |
| dma_done | input | 1 | Memory write committed |
| irq | output | 1 | Level interrupt |

## Verification
Register effects, the response and a raised `irq` from a data or interrupt-window write all appear in the cycle after the accepting edge. A compute write shows `dma_valid` one cycle after acceptance, and its `irq` only one cycle after the edge that samples `dma_done`. The bench drives every input on the falling edge. It then samples outputs on the next falling edge, or a fixed number of falling edges later, counted from these latencies. For stalls it samples `req_wait` just after driving the request and again one cycle later, before releasing `dma_done`.

// File: rtl/dbl_pkg.sv
// Shared types for the doubling peripheral: window codes and size codes.
package dbl_pkg;
    typedef enum logic [1:0] {
        WIN_DATA = 2'd0,
        WIN_CALC = 2'd1,
        WIN_IRQ  = 2'd2,
        WIN_BASE = 2'd3
    } win_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/dbl_decode.sv
// Request decoder: picks the window from the top address bits, qualifies
// access size, raises a stall for compute writes while a memory write is
// busy, and produces one-hot write strobes. Assumes BUS_W = 32 bit halves.
module dbl_decode
    import dbl_pkg::*;
#(
    parameter int APER_W = 6,
    parameter int HALVES = 2,
    localparam int ADDR_W = APER_W + 2
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              busy,
    output win_e              win,
    output logic              byte_ok,
    output logic              accept,
    output logic              stall,
    output logic              data_wr,
    output logic              calc_wr,
    output logic              flag_wr,
    output logic [HALVES-1:0] half_wr
);
    logic [APER_W-1:0] offs;
    logic              wr_acc;
    logic              word_ok;

    // Window, size and acceptance qualification.
    always_comb begin
        win     = win_e'(req_addr[ADDR_W-1 -: 2]);
        offs    = req_addr[APER_W-1:0];
        byte_ok = (req_size == SZ_BYTE);
        word_ok = (req_size == SZ_WORD);
        stall   = req_valid && req_write && (win == WIN_CALC) && byte_ok && busy;
        accept  = req_valid && !stall;
        wr_acc  = accept && req_write;
        data_wr = wr_acc && (win == WIN_DATA) && byte_ok;
        calc_wr = wr_acc && (win == WIN_CALC) && byte_ok;
        flag_wr = wr_acc && (win == WIN_IRQ)  && byte_ok;
    end

    // One strobe per 32-bit half of the target address, at offset 4*h.
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        assign half_wr[h] = wr_acc && (win == WIN_BASE) && word_ok &&
                            (offs == APER_W'(4 * h));
    end
endmodule

// File: rtl/dbl_regs.sv
// Register file: doubled data value, split target address, interrupt flag,
// and the registered read response. Assumes at most one strobe per cycle
// from the decoder; a memory-write completion wins over a flag clear.
module dbl_regs
    import dbl_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BUS_W  = 32,
    parameter int HALVES = 2,
    localparam int BASE_W = BUS_W * HALVES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic              flag_wr,
    input  logic [HALVES-1:0] half_wr,
    input  logic              done_ev,
    input  logic              accept,
    input  logic              req_write,
    input  win_e              win,
    input  logic              byte_ok,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BASE_W-1:0] base_q,
    output logic              flag_q,
    output logic              rsp_valid,
    output logic [BUS_W-1:0]  rsp_rdata
);
    logic [DATA_W-1:0] data_q;
    logic [BUS_W-1:0]  rd_mux;

    // Doubled data register.
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (data_wr) data_q <= DATA_W'({wdata[7:0], 1'b0});
    end

    // Target address halves, each written independently.
    for (genvar h = 0; h < HALVES; h++) begin : g_base
        always_ff @(posedge clk) begin
            if (!rst_n)          base_q[h*BUS_W +: BUS_W] <= '0;
            else if (half_wr[h]) base_q[h*BUS_W +: BUS_W] <= wdata;
        end
    end

    // Interrupt flag: host write first, set events override.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else begin
            if (flag_wr)            flag_q <= |wdata[7:0];
            if (data_wr || done_ev) flag_q <= 1'b1;
        end
    end

    // Read data selection per window.
    always_comb begin
        rd_mux = '1;
        case (win)
            WIN_DATA: if (byte_ok) rd_mux = BUS_W'(data_q);
            WIN_IRQ:  if (byte_ok) rd_mux = BUS_W'(flag_q);
            default:  rd_mux = '1;
        endcase
    end

    // Response register, one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= accept;
            rsp_rdata <= (accept && !req_write) ? rd_mux : '0;
        end
    end
endmodule

// File: rtl/dbl_dma.sv
// Single-beat write master: latches address and payload on start, holds
// them until the memory side reports completion. Assumes start only when idle.
module dbl_dma #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0] start_data,
    input  logic              dma_done,
    output logic              dma_valid,
    output logic [ADDR_W-1:0] dma_addr,
    output logic [DATA_W-1:0] dma_data,
    output logic              done_ev
);
    assign done_ev = dma_valid && dma_done;

    // Outstanding-write state and held payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_valid <= 1'b0;
            dma_addr  <= '0;
            dma_data  <= '0;
        end else if (start) begin
            dma_valid <= 1'b1;
            dma_addr  <= start_addr;
            dma_data  <= start_data;
        end else if (done_ev) begin
            dma_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/dbl_dma_periph.sv
// Top: doubling peripheral with four 64-byte windows and a result push to
// memory. Assumes DATA_W >= 9 and a 32-bit host data bus.
module dbl_dma_periph
    import dbl_pkg::*;
#(
    parameter int APER_W = 6,
    parameter int DATA_W = 16,
    parameter int BUS_W  = 32,
    parameter int HALVES = 2,
    localparam int ADDR_W = APER_W + 2,
    localparam int BASE_W = BUS_W * HALVES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [BUS_W-1:0]  req_wdata,
    output logic              req_wait,
    output logic              rsp_valid,
    output logic [BUS_W-1:0]  rsp_rdata,
    output logic              dma_valid,
    output logic [BASE_W-1:0] dma_addr,
    output logic [DATA_W-1:0] dma_data,
    input  logic              dma_done,
    output logic              irq
);
    win_e              win;
    logic              byte_ok, accept, data_wr, calc_wr, flag_wr, done_ev;
    logic [HALVES-1:0] half_wr;
    logic [BASE_W-1:0] base_q;

    dbl_decode #(.APER_W(APER_W), .HALVES(HALVES)) u_dec (
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .busy(dma_valid), .win(win), .byte_ok(byte_ok),
        .accept(accept), .stall(req_wait), .data_wr(data_wr),
        .calc_wr(calc_wr), .flag_wr(flag_wr), .half_wr(half_wr)
    );

    dbl_regs #(.DATA_W(DATA_W), .BUS_W(BUS_W), .HALVES(HALVES)) u_regs (
        .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .flag_wr(flag_wr),
        .half_wr(half_wr), .done_ev(done_ev), .accept(accept),
        .req_write(req_write), .win(win), .byte_ok(byte_ok),
        .wdata(req_wdata), .base_q(base_q), .flag_q(irq),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    dbl_dma #(.DATA_W(DATA_W), .ADDR_W(BASE_W)) u_dma (
        .clk(clk), .rst_n(rst_n), .start(calc_wr), .start_addr(base_q),
        .start_data(DATA_W'({req_wdata[7:0], 1'b0})), .dma_done(dma_done),
        .dma_valid(dma_valid), .dma_addr(dma_addr), .dma_data(dma_data),
        .done_ev(done_ev)
    );
endmodule

// File: rtl/dbl_dma_periph_chk.sv
// Protocol checker for the doubling peripheral, bound to the top module.
module dbl_dma_periph_chk #(
    parameter int ADDR_W = 8,
    parameter int BASE_W = 64,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic              req_wait,
    input logic              rsp_valid,
    input logic              dma_valid,
    input logic [BASE_W-1:0] dma_addr,
    input logic [DATA_W-1:0] dma_data,
    input logic              dma_done,
    input logic              irq
);
    logic [1:0] win;
    assign win = req_addr[ADDR_W-1 -: 2];

    AST_DMA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dma_valid && !dma_done |=> dma_valid && $stable(dma_addr) && $stable(dma_data)); // R5

    AST_DMA_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        dma_valid && dma_done |=> !dma_valid); // R5

    AST_WAIT_ONLY_CALC: assert property (@(posedge clk) disable iff (!rst_n)
        req_wait |-> dma_valid && req_valid && req_write && win == 2'd1 && req_size == 2'd0); // R7

    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_wait |=> rsp_valid); // R3

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(dma_valid && dma_done) ||
                       $past(req_valid && req_write && req_size == 2'd0 &&
                             (win == 2'd0 || win == 2'd2))); // R6
endmodule

bind dbl_dma_periph dbl_dma_periph_chk #(
    .ADDR_W(ADDR_W), .BASE_W(BASE_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wait(req_wait),
    .rsp_valid(rsp_valid), .dma_valid(dma_valid), .dma_addr(dma_addr),
    .dma_data(dma_data), .dma_done(dma_done), .irq(irq)
);

// File: tb/dbl_dma_periph_bench.sv
`timescale 1ns/1ps
module dbl_dma_periph_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        req_wait, rsp_valid, dma_valid, irq;
    logic [31:0] rsp_rdata;
    logic [63:0] dma_addr;
    logic [15:0] dma_data;
    logic        dma_done = 1'b0;

    int checks = 0, fails = 0, cyc = 0;

    logic [15:0] m_data = '0;
    logic [63:0] m_base = '0;
    logic        m_flag = 1'b0;

    always #2.5 clk = ~clk;

    dbl_dma_periph u_dbl_dma_periph (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .req_wait(req_wait), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .dma_valid(dma_valid), .dma_addr(dma_addr), .dma_data(dma_data),
        .dma_done(dma_done), .irq(irq)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000) begin
            checks++; fails++;
            $display("FAIL watchdog: run hung, act=%0d exp<=60000 cycles", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] dbl(input logic [7:0] b);
        return {7'd0, b, 1'b0};
    endfunction

    function automatic logic [31:0] exp_read(input logic [1:0] win, input logic [1:0] sz);
        if (win == 2'd0 && sz == 2'd0) return {16'd0, m_data};
        if (win == 2'd2 && sz == 2'd0) return {31'd0, m_flag};
        return 32'hFFFF_FFFF;
    endfunction

    // Start and end at a falling edge; wait while stalled.
    task automatic access(input logic w, input logic [1:0] win, input logic [5:0] off,
                          input logic [1:0] sz, input logic [31:0] wd, output logic [31:0] rd);
        req_valid = 1'b1; req_write = w; req_addr = {win, off};
        req_size = sz; req_wdata = wd;
        #1;
        while (req_wait) begin
            @(negedge clk); #1;
        end
        @(negedge clk);
        req_valid = 1'b0;
        rd = rsp_rdata;
        check(rsp_valid == 1'b1, "R3 rsp_valid", rsp_valid, 1);
    endtask

    // Completes an outstanding memory write after lat idle cycles.
    task automatic serve(input int lat, input logic [7:0] d);
        check(dma_valid && dma_addr == m_base, "R5 R10 dma_addr", dma_addr, m_base);
        check(dma_data == dbl(d), "R5 dma_data", dma_data, dbl(d));
        for (int i = 0; i < lat; i++) begin
            check(irq == m_flag, "R6 irq before done", irq, m_flag);
            @(negedge clk);
            check(dma_valid == 1'b1, "R5 dma held", dma_valid, 1);
        end
        check(irq == m_flag, "R6 irq before done", irq, m_flag);
        dma_done = 1'b1;
        @(negedge clk);
        dma_done = 1'b0;
        m_flag = 1'b1;
        check(dma_valid == 1'b0, "R5 dma retired", dma_valid, 0);
        check(irq == 1'b1, "R6 irq after done", irq, 1);
    endtask

    task automatic do_write(input logic [1:0] win, input logic [5:0] off, input logic [1:0] sz,
                            input logic [31:0] wd, input int lat);
        logic [31:0] rd;
        access(1'b1, win, off, sz, wd, rd);
        case (win)
            2'd0: if (sz == 0) begin m_data = dbl(wd[7:0]); m_flag = 1'b1; end
            2'd2: if (sz == 0) m_flag = (wd[7:0] != 0);
            2'd3: if (sz == 2) begin
                      if (off == 6'd0) m_base[31:0]  = wd;
                      if (off == 6'd4) m_base[63:32] = wd;
                  end
            default: ;
        endcase
        if (win == 2'd1 && sz == 0) serve(lat, wd[7:0]);
        else begin
            check(dma_valid == 1'b0, "R4 R10 no dma", dma_valid, 0);
            check(irq == m_flag, "R2 R4 R9 irq level", irq, m_flag);
        end
    endtask

    task automatic do_read(input logic [1:0] win, input logic [5:0] off, input logic [1:0] sz, input string tag);
        logic [31:0] rd, ex;
        ex = exp_read(win, sz);
        access(1'b0, win, off, sz, 32'h0, rd);
        check(rd == ex, tag, rd, ex);
    endtask

    initial begin
        logic [31:0] rd;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(irq == 1'b0, "R1 irq", irq, 0);
        check(dma_valid == 1'b0, "R1 dma_valid", dma_valid, 0);
        do_read(2'd0, 6'd0, 2'd0, "R1 R3 data zero");
        do_read(2'd2, 6'd0, 2'd0, "R1 R9 flag zero");
        do_write(2'd1, 6'd0, 2'd0, 32'h81, 2);          // R1 base zero, R5, R6

        // R9 clear then set
        do_write(2'd2, 6'd3, 2'd0, 32'h0, 0);
        do_read(2'd2, 6'd0, 2'd0, "R9 flag cleared");
        do_write(2'd2, 6'd0, 2'd0, 32'h40, 0);
        do_read(2'd2, 6'd9, 2'd0, "R9 R11 flag set");
        do_write(2'd2, 6'd0, 2'd0, 32'hFF00, 0);        // R11 only byte 0 counts
        check(irq == 1'b0, "R9 R11 upper bytes ignored", irq, 0);

        // R4 non-byte accesses
        do_write(2'd0, 6'd0, 2'd1, 32'h55, 0);
        do_read(2'd0, 6'd0, 2'd0, "R4 data unchanged");
        do_read(2'd0, 6'd0, 2'd2, "R4 wide read ones");
        do_write(2'd1, 6'd0, 2'd3, 32'h12, 0);

        // R2 max byte
        do_write(2'd0, 6'd21, 2'd0, 32'hFF, 0);
        do_read(2'd0, 6'd0, 2'd0, "R2 R3 doubled 0x1FE");

        // R8 unreadable windows
        do_read(2'd1, 6'd0, 2'd0, "R8 calc read");
        do_read(2'd3, 6'd0, 2'd2, "R8 base read");

        // R10 halves and ignored writes
        do_write(2'd3, 6'd0, 2'd2, 32'hDEAD_BEEF, 0);
        do_write(2'd3, 6'd4, 2'd2, 32'h0123_4567, 0);
        do_write(2'd3, 6'd0, 2'd0, 32'h0000_00AA, 0);
        do_write(2'd3, 6'd8, 2'd2, 32'h5555_5555, 0);
        do_write(2'd2, 6'd0, 2'd0, 32'h0, 0);
        do_write(2'd1, 6'd7, 2'd0, 32'h3C, 1);          // R10 via dma_addr, R6 rise from 0

        // R7 stall while outstanding
        do_write(2'd2, 6'd0, 2'd0, 32'h0, 0);
        access(1'b1, 2'd1, 6'd0, 2'd0, 32'h11, rd);
        req_valid = 1'b1; req_write = 1'b1; req_addr = {2'd1, 6'd0};
        req_size = 2'd0; req_wdata = 32'h22;
        #1;
        check(req_wait == 1'b1, "R7 wait asserted", req_wait, 1);
        @(negedge clk); #1;
        check(req_wait == 1'b1, "R7 wait held", req_wait, 1);
        check(dma_data == dbl(8'h11), "R7 first payload kept", dma_data, dbl(8'h11));
        dma_done = 1'b1;
        @(negedge clk);
        dma_done = 1'b0;
        m_flag = 1'b1;
        #1;
        check(req_wait == 1'b0, "R7 wait released", req_wait, 0);
        check(irq == 1'b1, "R6 first done irq", irq, 1);
        @(negedge clk);
        req_valid = 1'b0;
        check(dma_valid == 1'b1, "R7 second accepted", dma_valid, 1);
        serve(0, 8'h22);

        // Random mix
        for (int n = 0; n < 500; n++) begin
            logic [1:0]  win, sz;
            logic [5:0]  off;
            logic [31:0] wd;
            win = 2'($urandom % 4);
            sz  = (win == 2'd3) ? 2'd2 : 2'd0;
            if ($urandom % 5 == 0) sz = 2'($urandom % 4);
            off = 6'($urandom % 64);
            if (win == 2'd3 && ($urandom % 4 != 0)) off = ($urandom % 2) ? 6'd4 : 6'd0;
            wd = $urandom;
            if ($urandom % 2) do_write(win, off, sz, wd, int'($urandom % 4));
            else do_read(win, off, sz, "R3 R4 R8 R9 R11 random read");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule